// File: doc/BRIEF.md
# Watchpoint Comparator Bank

This block holds a small set of match comparators that observe a processor's instruction fetch bus, its data access bus and a free-running cycle counter. Each comparator stores a compare value, an address mask and a function word. When its programmed condition holds, it raises an event on its own output bit. Depending on which debug function owns the comparator, that event is either a halt request or a trace trigger. Software programs the comparators through a plain register write port and reads them back through a combinational read port. The read port also returns a capability word that describes how the bank was built.

The comparators are deliberately unequal. Comparator 0 alone can match the cycle counter, and comparator 1 alone can match a data value, and only when the bank is built with that option. A comparator belongs either to the breakpoint function or to the trace function. A function write that would hand a claimed comparator to the other function is refused, and the stored function stays as it was. Every comparator also keeps a sticky matched flag that software clears by writing ones.

Top module: `watch_cmp_bank`

## Requirements
- R1: The parameter NUM_CMP (1 to 4) sets how many comparators exist. A read with rd_sel = 3 returns the capability word: bits [2:0] hold NUM_CMP, bit 3 is 1 when data value matching is built in (HAS_DVAL), and all other bits are 0.
- R2: A write with cfg_sel = 0 sets the compare value, cfg_sel = 1 sets the mask (bits [3:0]) and cfg_sel = 2 sets the function word. All three read back at the same rd_sel codes. The function word holds kind in bits [2:0] (0 off, 1 fetch address, 2 data address, 3 data value, 4 cycle count), read enable in bit 3, write enable in bit 4 and owner in bit 5 (0 breakpoint, 1 trace).
- R3: Kind 1 on any comparator matches a valid fetch whose address equals the compare value, ignoring the number of low bits given by the mask (0 to 15).
- R4: Kind 2 on any comparator matches a valid data access whose address equals the compare value under the same mask, but only when the access direction is enabled: bit 3 for reads and bit 4 for writes.
- R5: Kind 3 is accepted only on comparator 1, and only when HAS_DVAL is set. It matches an enabled-direction access whose data equals the full compare value. A kind 3 write to any other comparator is refused and leaves the function word unchanged.
- R6: Kind 4 is accepted only on comparator 0. It matches on the single cycle in which the wrapping 32-bit cycle counter equals the compare value. The counter is 0 in reset, increments every clock and is visible on cycle_count. A kind 4 write to any other comparator is refused.
- R7: A function write whose owner bit differs from the stored owner of a comparator whose kind is not off is refused, including a write that would switch it off. A comparator whose kind is off accepts either owner.
- R8: A match on an owner-0 comparator drives its halt_req bit, and a match on an owner-1 comparator drives its trace_trig bit. Both are registered and appear one clock after the matching bus cycle or counter value.
- R9: halt_req is a single-cycle pulse on the first cycle of a run of consecutive matches. trace_trig is high for every matching cycle.
- R10: Every match sets that comparator's matched bit. The bit stays set until a write with cfg_sel = 3 carries a 1 in that bit position of cfg_wdata. A match in the same cycle as the clear wins.
- R11: After reset all function words, values and masks are 0, all event and matched outputs are 0, and cycle_count starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Comparator selected by the write |
| cfg_sel | input | 2 | Write target: 0 value, 1 mask, 2 function, 3 matched-flag clear |
| cfg_wdata | input | W | Write data |
| rd_idx | input | 2 | Comparator selected by the read |
| rd_sel | input | 2 | Read target: 0 value, 1 mask, 2 function, 3 capability word |
| rd_data | output | W | Combinational read data |
| if_valid | input | 1 | Instruction fetch valid |
| if_addr | input | W | Instruction fetch address |
| da_valid | input | 1 | Data access valid |
| da_write | input | 1 | Data access is a write |
| da_addr | input | W | Data access address |
| da_data | input | W | Data access value |
| cycle_count | output | W | Free-running cycle counter |
| halt_req | output | NUM_CMP | Per-comparator halt request pulses |
| trace_trig | output | NUM_CMP | Per-comparator trace trigger |
| matched | output | NUM_CMP | Per-comparator sticky matched flags |

## Verification
A bus cycle driven before clock edge k shows up as halt_req, trace_trig and matched right after edge k. So the driver pushes each cycle's expected event vector into a queue at the falling edge where it drives the bus, and the monitor pops that entry two time units after the next rising edge. A register write lands on the following rising edge, and the read port is combinational, so every readback is compared one clock after its write, a moment after a falling edge. For a cycle-count compare, the driver predicts the event on the cycle in which the observed counter equals the programmed value, and the event is due one edge later. Because every driven cycle is queued, a halt pulse that lasts too long or an event that should not appear is caught as well.

// File: rtl/wcb_pkg.sv
`timescale 1ns/1ps
package wcb_pkg;
   localparam logic [2:0] K_OFF   = 3'd0;
   localparam logic [2:0] K_FETCH = 3'd1;
   localparam logic [2:0] K_DADDR = 3'd2;
   localparam logic [2:0] K_DVAL  = 3'd3;
   localparam logic [2:0] K_CYC   = 3'd4;

   localparam logic [1:0] SEL_VAL  = 2'd0;
   localparam logic [1:0] SEL_MASK = 2'd1;
   localparam logic [1:0] SEL_FUNC = 2'd2;
   localparam logic [1:0] SEL_CTL  = 2'd3;

   // function word: owner, write enable, read enable, kind
   typedef struct packed {
      logic       use_trace;
      logic       wr_en;
      logic       rd_en;
      logic [2:0] kind;
   } func_t;

   localparam int FUNC_W = $bits(func_t);
endpackage

// File: rtl/wcb_cycle_ctr.sv
`timescale 1ns/1ps
module wcb_cycle_ctr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end
endmodule

// File: rtl/wcb_slot.sv
`timescale 1ns/1ps
module wcb_slot
   import wcb_pkg::*;
#(
   parameter int W        = 32,
   parameter int MASK_W   = 4,
   parameter bit CAN_DVAL = 1'b0,
   parameter bit CAN_CYC  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [W-1:0]      wr_data,
   input  logic              if_valid,
   input  logic [W-1:0]      if_addr,
   input  logic              da_valid,
   input  logic              da_write,
   input  logic [W-1:0]      da_addr,
   input  logic [W-1:0]      da_data,
   input  logic [W-1:0]      cyc_now,
   output logic [W-1:0]      val_q,
   output logic [MASK_W-1:0] mask_q,
   output func_t             func_q,
   output logic              hit,
   output logic              use_trace
);
   func_t      new_func;
   logic       kind_legal;
   logic       owner_ok;
   logic [W-1:0] keep;
   logic       dir_ok;
   logic       fetch_hit;
   logic       daddr_hit;
   logic       dval_hit;
   logic       cyc_hit;

   assign new_func = func_t'(wr_data[FUNC_W-1:0]);

   always_comb begin
      case (new_func.kind)
         K_OFF, K_FETCH, K_DADDR: kind_legal = 1'b1;
         K_DVAL:                  kind_legal = CAN_DVAL;
         K_CYC:                   kind_legal = CAN_CYC;
         default:                 kind_legal = 1'b0;
      endcase
   end

   // a claimed comparator may only be rewritten by its current owner
   assign owner_ok = (func_q.kind == K_OFF) || (func_q.use_trace == new_func.use_trace);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         mask_q <= '0;
         func_q <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_VAL:  val_q  <= wr_data;
            SEL_MASK: mask_q <= wr_data[MASK_W-1:0];
            SEL_FUNC: if (kind_legal && owner_ok) func_q <= new_func;
            default:  ;
         endcase
      end
   end

   assign keep      = {W{1'b1}} << mask_q;
   assign dir_ok    = da_write ? func_q.wr_en : func_q.rd_en;
   assign fetch_hit = if_valid && (((if_addr ^ val_q) & keep) == '0);
   assign daddr_hit = da_valid && dir_ok && (((da_addr ^ val_q) & keep) == '0);

   generate
      if (CAN_DVAL) begin : g_dval
         assign dval_hit = da_valid && dir_ok && (da_data == val_q);
      end else begin : g_no_dval
         logic unused_dval;
         assign unused_dval = ^da_data;
         assign dval_hit    = 1'b0;
      end
      if (CAN_CYC) begin : g_cyc
         assign cyc_hit = (cyc_now == val_q);
      end else begin : g_no_cyc
         logic unused_cyc;
         assign unused_cyc = ^cyc_now;
         assign cyc_hit    = 1'b0;
      end
   endgenerate

   always_comb begin
      case (func_q.kind)
         K_FETCH: hit = fetch_hit;
         K_DADDR: hit = daddr_hit;
         K_DVAL:  hit = dval_hit;
         K_CYC:   hit = cyc_hit;
         default: hit = 1'b0;
      endcase
   end

   assign use_trace = func_q.use_trace;
endmodule

// File: rtl/wcb_event.sv
`timescale 1ns/1ps
module wcb_event #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] use_trace,
   input  logic [N-1:0] clr,
   output logic [N-1:0] halt_req,
   output logic [N-1:0] trace_trig,
   output logic [N-1:0] matched
);
   logic [N-1:0] hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q      <= '0;
         halt_req   <= '0;
         trace_trig <= '0;
         matched    <= '0;
      end else begin
         hit_q      <= hit;
         halt_req   <= hit & ~hit_q & ~use_trace;
         trace_trig <= hit & use_trace;
         matched    <= (matched & ~clr) | hit;
      end
   end
endmodule

// File: rtl/watch_cmp_bank.sv
`timescale 1ns/1ps
module watch_cmp_bank
   import wcb_pkg::*;
#(
   parameter int NUM_CMP  = 4,
   parameter int W        = 32,
   parameter int MASK_W   = 4,
   parameter bit HAS_DVAL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_idx,
   input  logic [1:0]         cfg_sel,
   input  logic [W-1:0]       cfg_wdata,
   input  logic [1:0]         rd_idx,
   input  logic [1:0]         rd_sel,
   output logic [W-1:0]       rd_data,
   input  logic               if_valid,
   input  logic [W-1:0]       if_addr,
   input  logic               da_valid,
   input  logic               da_write,
   input  logic [W-1:0]       da_addr,
   input  logic [W-1:0]       da_data,
   output logic [W-1:0]       cycle_count,
   output logic [NUM_CMP-1:0] halt_req,
   output logic [NUM_CMP-1:0] trace_trig,
   output logic [NUM_CMP-1:0] matched
);
   localparam int MAX_IGN = (1 << MASK_W) - 1;
   localparam logic [W-1:0] CAP_WORD = W'({HAS_DVAL, 3'(NUM_CMP)});

   generate
      if (NUM_CMP < 1 || NUM_CMP > 4) begin : g_bad_count
         $error("watch_cmp_bank: NUM_CMP must lie in 1..4");
      end
      if (W < MAX_IGN + 1 || W < 8) begin : g_bad_width
         $error("watch_cmp_bank: W too narrow for the mask range");
      end
   endgenerate

   logic [W-1:0]       val_a  [NUM_CMP];
   logic [MASK_W-1:0]  mask_a [NUM_CMP];
   func_t              func_a [NUM_CMP];
   logic [NUM_CMP-1:0] hit_v;
   logic [NUM_CMP-1:0] use_v;
   logic [NUM_CMP-1:0] clr_v;

   wcb_cycle_ctr #(.W(W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .count (cycle_count)
   );

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
         localparam bit DV = (i == 1) && HAS_DVAL;
         localparam bit CY = (i == 0);
         wcb_slot #(
            .W        (W),
            .MASK_W   (MASK_W),
            .CAN_DVAL (DV),
            .CAN_CYC  (CY)
         ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_idx == 2'(i)) && (cfg_sel != SEL_CTL)),
            .wr_sel    (cfg_sel),
            .wr_data   (cfg_wdata),
            .if_valid  (if_valid),
            .if_addr   (if_addr),
            .da_valid  (da_valid),
            .da_write  (da_write),
            .da_addr   (da_addr),
            .da_data   (da_data),
            .cyc_now   (cycle_count),
            .val_q     (val_a[i]),
            .mask_q    (mask_a[i]),
            .func_q    (func_a[i]),
            .hit       (hit_v[i]),
            .use_trace (use_v[i])
         );
      end
   endgenerate

   assign clr_v = (cfg_we && cfg_sel == SEL_CTL) ? cfg_wdata[NUM_CMP-1:0] : '0;

   wcb_event #(.N(NUM_CMP)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit_v),
      .use_trace  (use_v),
      .clr        (clr_v),
      .halt_req   (halt_req),
      .trace_trig (trace_trig),
      .matched    (matched)
   );

   always_comb begin
      rd_data = '0;
      if (rd_sel == SEL_CTL) begin
         rd_data = CAP_WORD;
      end else begin
         for (int i = 0; i < NUM_CMP; i++) begin
            if (rd_idx == 2'(i)) begin
               case (rd_sel)
                  SEL_VAL:  rd_data = val_a[i];
                  SEL_MASK: rd_data = W'(mask_a[i]);
                  SEL_FUNC: rd_data = W'(func_a[i]);
                  default:  rd_data = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/wcb_chk.sv
`timescale 1ns/1ps
module wcb_chk #(
   parameter int N = 4,
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cfg_we,
   input logic [1:0]   cfg_sel,
   input logic [N-1:0] clr_bits,
   input logic [N-1:0] halt_req,
   input logic [N-1:0] trace_trig,
   input logic [N-1:0] matched,
   input logic [W-1:0] cycle_count
);
   logic [N-1:0] clr_mask;
   assign clr_mask = (cfg_we && cfg_sel == 2'd3) ? clr_bits : '0;

   AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req & $past(halt_req)) == '0); // R9

   AST_ACTION_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req & trace_trig) == '0); // R8

   AST_EVENT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ((halt_req | trace_trig) & ~matched) == '0); // R10

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(matched) & ~matched & ~$past(clr_mask)) == '0)); // R10

   AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cycle_count == $past(cycle_count) + 1'b1)); // R6
endmodule

bind watch_cmp_bank wcb_chk #(.N(NUM_CMP), .W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_sel     (cfg_sel),
   .clr_bits    (cfg_wdata[NUM_CMP-1:0]),
   .halt_req    (halt_req),
   .trace_trig  (trace_trig),
   .matched     (matched),
   .cycle_count (cycle_count)
);

// File: tb/watch_cmp_bank_test.sv
`timescale 1ns/1ps
module watch_cmp_bank_test;
   localparam int N = 4;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_we;
   logic [1:0]   cfg_idx, cfg_sel, rd_idx, rd_sel;
   logic [W-1:0] cfg_wdata, rd_data, if_addr, da_addr, da_data, cycle_count;
   logic         if_valid, da_valid, da_write;
   logic [N-1:0] halt_req, trace_trig, matched;

   typedef struct {
      logic [N-1:0] h;
      logic [N-1:0] t;
      logic [N-1:0] m;
      string        tag;
   } exp_t;

   exp_t         q[$];
   int           checks = 0;
   int           fails  = 0;
   logic [N-1:0] em     = '0;
   bit           done   = 1'b0;

   always #5 clk = ~clk;

   watch_cmp_bank #(.NUM_CMP(N), .W(W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_data(rd_data),
      .if_valid(if_valid), .if_addr(if_addr), .da_valid(da_valid), .da_write(da_write),
      .da_addr(da_addr), .da_data(da_data), .cycle_count(cycle_count),
      .halt_req(halt_req), .trace_trig(trace_trig), .matched(matched)
   );

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic push(logic [N-1:0] h, logic [N-1:0] t, string tag);
      exp_t e;
      em    = em | h | t;
      e.h   = h;
      e.t   = t;
      e.m   = em;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle_drive();
      cfg_we   = 1'b0;
      if_valid = 1'b0;
      da_valid = 1'b0;
      da_write = 1'b0;
   endtask

   task automatic idle(string tag);
      @(negedge clk);
      idle_drive();
      push('0, '0, tag);
   endtask

   task automatic wr(int idx, int sel, logic [W-1:0] data, string tag);
      @(negedge clk);
      idle_drive();
      cfg_we    = 1'b1;
      cfg_idx   = 2'(idx);
      cfg_sel   = 2'(sel);
      cfg_wdata = data;
      if (sel == 3) em = em & ~data[N-1:0];
      push('0, '0, tag);
   endtask

   task automatic fetch(logic [W-1:0] a, logic [N-1:0] h, logic [N-1:0] t, string tag);
      @(negedge clk);
      idle_drive();
      if_valid = 1'b1;
      if_addr  = a;
      push(h, t, tag);
   endtask

   task automatic dacc(logic w, logic [W-1:0] a, logic [W-1:0] d,
                       logic [N-1:0] h, logic [N-1:0] t, string tag);
      @(negedge clk);
      idle_drive();
      da_valid = 1'b1;
      da_write = w;
      da_addr  = a;
      da_data  = d;
      push(h, t, tag);
   endtask

   task automatic rd_chk(int idx, int sel, logic [W-1:0] exp, string tag);
      @(negedge clk);
      idle_drive();
      push('0, '0, tag);
      rd_idx = 2'(idx);
      rd_sel = 2'(sel);
      #1;
      chk(tag, rd_data, exp);
   endtask

   // monitor: compares each queued expectation one edge after it was driven
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({halt_req, trace_trig, matched} !== {e.h, e.t, e.m}) begin
               fails++;
               $display("FAIL %s: actual halt=%b trig=%b matched=%b expected halt=%b trig=%b matched=%b",
                        e.tag, halt_req, trace_trig, matched, e.h, e.t, e.m);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v;
      int           fired;
      rst_n = 1'b0;
      idle_drive();
      cfg_idx = '0; cfg_sel = '0; cfg_wdata = '0;
      rd_idx = '0; rd_sel = '0;
      if_addr = '0; da_addr = '0; da_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 events after reset", W'({halt_req, trace_trig, matched}), '0);
      chk("R11 counter one cycle after reset", cycle_count, 32'd1);
      rd_chk(0, 2, 32'd0, "R11 function word after reset");
      rd_chk(3, 0, 32'd0, "R11 value after reset");
      rd_chk(0, 3, 32'h0000_000C, "R1 capability word");

      // R2/R3 fetch address on comparator 2, ignore 4 low bits, breakpoint owner
      wr(2, 0, 32'h1000_0040, "R2 value write");
      wr(2, 1, 32'd4, "R2 mask write");
      wr(2, 2, 32'd1, "R2 function write");
      rd_chk(2, 2, 32'd1, "R2 function readback");
      rd_chk(2, 1, 32'd4, "R2 mask readback");
      fetch(32'h1000_004C, 4'b0100, '0, "R3/R8 masked fetch halts");
      fetch(32'h1000_004C, '0, '0, "R9 no second halt pulse");
      fetch(32'h1000_0050, '0, '0, "R3 bit above mask misses");
      fetch(32'h1000_0040, 4'b0100, '0, "R9 new run halts again");
      idle("R10 matched stays set");
      wr(0, 3, 32'h4, "R10 clear flag 2");
      idle("R10 flag cleared");

      // R4 data address on comparator 3, reads only, trace owner
      wr(3, 0, 32'h2000_0000, "R4 value write");
      wr(3, 2, 32'd42, "R4 function write");
      dacc(1'b0, 32'h2000_0000, 32'h0, '0, 4'b1000, "R4/R8 read access triggers trace");
      dacc(1'b1, 32'h2000_0000, 32'h0, '0, '0, "R4 write direction disabled");
      dacc(1'b0, 32'h2000_0004, 32'h0, '0, '0, "R4 unmasked address miss");

      // R5 data value only on comparator 1
      wr(2, 2, 32'd3, "R5 value kind on comparator 2");
      rd_chk(2, 2, 32'd1, "R5 refused on comparator 2");
      wr(0, 2, 32'd3, "R5 value kind on comparator 0");
      rd_chk(0, 2, 32'd0, "R5 refused on comparator 0");
      wr(1, 0, 32'hDEAD_BEEF, "R5 value write");
      wr(1, 2, 32'd27, "R5 function write");
      rd_chk(1, 2, 32'd27, "R5 accepted on comparator 1");
      dacc(1'b1, 32'h3000_0000, 32'hDEAD_BEEF, 4'b0010, '0, "R5 data value halts");
      dacc(1'b0, 32'h3000_0000, 32'h0000_1234, '0, '0, "R5 other data misses");

      // R7 ownership
      wr(2, 2, 32'd33, "R7 trace claim of breakpoint comparator");
      rd_chk(2, 2, 32'd1, "R7 claim refused");
      wr(2, 2, 32'd32, "R7 release by other owner");
      rd_chk(2, 2, 32'd1, "R7 release refused");
      wr(2, 2, 32'd0, "R7 release by owner");
      rd_chk(2, 2, 32'd0, "R7 release accepted");
      wr(2, 2, 32'd33, "R7 trace claim of free comparator");
      rd_chk(2, 2, 32'd33, "R7 claim accepted");
      fetch(32'h1000_0040, '0, 4'b0100, "R7/R8 new owner triggers trace");
      fetch(32'h1000_0040, '0, 4'b0100, "R9 trace every matching cycle");

      // R6 cycle count only on comparator 0
      wr(1, 2, 32'd4, "R6 cycle kind on comparator 1");
      rd_chk(1, 2, 32'd27, "R6 refused on comparator 1");
      @(negedge clk);
      idle_drive();
      push('0, '0, "R6 idle");
      v = cycle_count + 32'd40;
      wr(0, 0, v, "R6 value write");
      wr(0, 2, 32'd36, "R6 function write");
      fired = 0;
      for (int k = 0; k < 80; k++) begin
         @(negedge clk);
         idle_drive();
         if (cycle_count == v) begin
            push('0, 4'b0001, "R6 cycle compare fires");
            fired++;
         end else begin
            push('0, '0, "R6 no fire off the compare cycle");
         end
      end
      chk("R6 single cycle match", W'(fired), 32'd1);

      wr(0, 3, 32'hF, "R10 clear all flags");
      idle("R10 all flags cleared");
      repeat (3) idle("drain");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule